// File: doc/BRIEF.md
# Voltage–Frequency Operating Point Sequencer

This block moves a processor core between four fixed voltage–frequency operating points whenever software asks for one. It drives a voltage code to an on-chip regulator and a frequency code to a clock generator. It changes only one of the two at a time and waits for the matching settle input (regulator ready or clock lock) before it takes the next step. The order of the two steps depends on direction. When the core speeds up, the supply is raised first and the clock second. When it slows down, the clock is lowered first and the supply second. As a result the supply is never too low for the running clock. The core clock enable is held low while the clock generator relocks.

A request is a single-cycle pulse that carries a point index. The block answers with a busy level and a one-cycle done pulse. A request that arrives while a change is under way is refused and sets a sticky flag. A wait that outlasts a programmable cycle limit makes the block restore the codes of the point it started from and sets a second sticky flag. A saturating counter records every completed change, so software can weigh how often it pays the switching cost.

Top module: `dvfs_seq`

## Requirements
- R1: After reset the block sits at point 0 with voltage code 12 and frequency code 40, core clock enable high, busy, done and both error flags low, and the transition count zero. Points 0 to 3 map to voltage codes 12, 10, 8, 6 (units of 100 mV) and frequency codes 40, 30, 16, 4 (units of 5 MHz).
- R2: On a request for a lower index (faster), the voltage code changes first. The frequency code changes only after regulator ready has been seen.
- R3: On a request for a higher index (slower), the frequency code changes first. The voltage code changes only after clock lock has been seen. At every cycle the voltage code is at least the one its frequency code needs.
- R4: Core clock enable goes low in the same cycle the frequency code changes, and it stays low until clock lock is seen.
- R5: A settle input is ignored in the first cycle after its code changes. With settle inputs held high throughout, a change shows busy for exactly 4 cycles before done.
- R6: A request for the current point gives done on the next cycle and changes neither code nor count.
- R7: A request while busy is ignored and sets the sticky busy-error flag.
- R8: Each completed change increments the transition count by one, and the count saturates at its maximum (255 by default).
- R9: If the awaited settle input is still absent once the timer reaches the timeout value, both codes return to those of the starting point together and the sticky timeout flag is set. Done then follows after the restore settles or times out, with the point and count unchanged.
- R10: Busy is high from the cycle after an accepted change request until the cycle done is pulsed. Done is never high together with busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_point | input | 2 | Requested operating point index |
| timeout_cycles | input | TO_W | Settle wait limit in cycles |
| vreg_ready | input | 1 | Regulator output settled |
| clk_locked | input | 1 | Clock generator locked |
| vsel | output | VC_W | Voltage code to regulator |
| fsel | output | FC_W | Frequency code to clock generator |
| core_clk_en | output | 1 | Core clock enable |
| busy | output | 1 | Change under way |
| done | output | 1 | One-cycle completion pulse |
| cur_point | output | 2 | Operating point in force |
| err_busy | output | 1 | Sticky: request refused while busy |
| err_timeout | output | 1 | Sticky: settle wait expired |
| trans_count | output | CNT_W | Saturating count of completed changes |

## Verification
The embedded properties assume that req_valid is a single-cycle strobe and that timeout_cycles is at least 2 and stays steady while a change is under way. They also assume that the regulator and clock generator models drop their settle signal no earlier than one cycle after a code change. The bench's behavioural models follow these rules. They drop ready or lock on the edge after they see a new code and recover after a fixed delay, unless a test holds them in a stuck or stale mode on purpose. Requests are issued only between negative edges with a fixed timeout of 20.

// File: rtl/dvfs_seq.sv
module dvfs_seq #(
  parameter int VC_W  = 4,
  parameter int FC_W  = 6,
  parameter int TO_W  = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_point,
  input  logic [TO_W-1:0]  timeout_cycles,
  input  logic             vreg_ready,
  input  logic             clk_locked,
  output logic [VC_W-1:0]  vsel,
  output logic [FC_W-1:0]  fsel,
  output logic             core_clk_en,
  output logic             busy,
  output logic             done,
  output logic [1:0]       cur_point,
  output logic             err_busy,
  output logic             err_timeout,
  output logic [CNT_W-1:0] trans_count
);

  typedef enum logic [2:0] {ST_IDLE, ST_VUP, ST_FUP, ST_FDN, ST_VDN, ST_RB} st_t;

  function automatic logic [VC_W-1:0] v_of(input logic [1:0] p);
    return VC_W'(12 - 2 * int'(p));
  endfunction

  function automatic logic [FC_W-1:0] f_of(input logic [1:0] p);
    case (p)
      2'd0:    return FC_W'(40);
      2'd1:    return FC_W'(30);
      2'd2:    return FC_W'(16);
      default: return FC_W'(4);
    endcase
  endfunction

  function automatic logic [VC_W-1:0] v_need(input logic [FC_W-1:0] f);
    if (f > FC_W'(30))      return VC_W'(12);
    else if (f > FC_W'(16)) return VC_W'(10);
    else if (f > FC_W'(4))  return VC_W'(8);
    else                    return VC_W'(6);
  endfunction

  st_t             st;
  logic [1:0]      tgt;
  logic [TO_W-1:0] timer;
  logic            v_ok, f_ok, settled, expired, go_rb;

  assign v_ok    = (timer != '0) && vreg_ready;
  assign f_ok    = (timer != '0) && clk_locked;
  assign expired = timer >= timeout_cycles;
  assign busy    = st != ST_IDLE;

  always_comb begin
    case (st)
      ST_VUP, ST_VDN: settled = v_ok;
      ST_FUP, ST_FDN: settled = f_ok;
      ST_RB:          settled = v_ok && f_ok;
      default:        settled = 1'b0;
    endcase
  end

  assign go_rb = (st inside {ST_VUP, ST_FUP, ST_FDN, ST_VDN}) && !settled && expired;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      tgt         <= 2'd0;
      timer       <= '0;
      cur_point   <= 2'd0;
      vsel        <= v_of(2'd0);
      fsel        <= f_of(2'd0);
      core_clk_en <= 1'b1;
      done        <= 1'b0;
      err_busy    <= 1'b0;
      err_timeout <= 1'b0;
      trans_count <= '0;
    end else begin
      done <= 1'b0;
      if (req_valid && busy) err_busy <= 1'b1;
      if (go_rb) begin
        vsel        <= v_of(cur_point);
        fsel        <= f_of(cur_point);
        core_clk_en <= 1'b0;
        err_timeout <= 1'b1;
        timer       <= '0;
        st          <= ST_RB;
      end else begin
        case (st)
          ST_IDLE: begin
            timer <= '0;
            if (req_valid) begin
              if (req_point == cur_point) begin
                done <= 1'b1;
              end else begin
                tgt <= req_point;
                if (req_point < cur_point) begin
                  vsel <= v_of(req_point);
                  st   <= ST_VUP;
                end else begin
                  fsel        <= f_of(req_point);
                  core_clk_en <= 1'b0;
                  st          <= ST_FDN;
                end
              end
            end
          end
          ST_VUP: begin
            if (settled) begin
              fsel        <= f_of(tgt);
              core_clk_en <= 1'b0;
              timer       <= '0;
              st          <= ST_FUP;
            end else timer <= timer + 1'b1;
          end
          ST_FDN: begin
            if (settled) begin
              core_clk_en <= 1'b1;
              vsel        <= v_of(tgt);
              timer       <= '0;
              st          <= ST_VDN;
            end else timer <= timer + 1'b1;
          end
          ST_FUP, ST_VDN: begin
            if (settled) begin
              core_clk_en <= 1'b1;
              cur_point   <= tgt;
              done        <= 1'b1;
              if (!(&trans_count)) trans_count <= trans_count + 1'b1;
              st          <= ST_IDLE;
            end else timer <= timer + 1'b1;
          end
          ST_RB: begin
            if (settled || expired) begin
              core_clk_en <= 1'b1;
              done        <= 1'b1;
              st          <= ST_IDLE;
            end else timer <= timer + 1'b1;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  AST_SAFE_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    vsel >= v_need(fsel)); // R3
  AST_STEP_APART: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(vsel) && !$stable(fsel)) |-> err_timeout); // R9
  AST_GATED_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fsel) |-> !core_clk_en); // R4
  AST_REFUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> err_busy); // R7
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    err_busy |=> err_busy); // R7
  AST_SAME_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_point == cur_point) |=> (done && $stable(vsel) && $stable(fsel))); // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trans_count) |-> (done && trans_count == $past(trans_count) + 1'b1)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10

endmodule

// File: tb/sim_dvfs_seq.sv
module sim_dvfs_seq;
  localparam int RD = 5;
  localparam int LD = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_point = 2'd0;
  logic [15:0] timeout_cycles = 16'd20;
  logic vreg_ready, clk_locked;
  logic [3:0] vsel;
  logic [5:0] fsel;
  logic core_clk_en, busy, done, err_busy, err_timeout;
  logic [1:0] cur_point;
  logic [7:0] trans_count;

  always #5 clk = ~clk;

  dvfs_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_point(req_point),
    .timeout_cycles(timeout_cycles), .vreg_ready(vreg_ready), .clk_locked(clk_locked),
    .vsel(vsel), .fsel(fsel), .core_clk_en(core_clk_en), .busy(busy), .done(done),
    .cur_point(cur_point), .err_busy(err_busy), .err_timeout(err_timeout),
    .trans_count(trans_count)
  );

  int vectors = 0;
  int miscompares = 0;
  bit stale = 0, reg_dead = 0, pll_dead = 0;

  typedef struct { logic [1:0] pt; int cnt; logic to; } item_t;
  item_t q[$];
  logic [1:0] exp_pt = 2'd0;
  int exp_cnt = 0;
  logic exp_to = 1'b0;

  function automatic int vt(input logic [1:0] p);
    return 12 - 2 * int'(p);
  endfunction
  function automatic int ft(input logic [1:0] p);
    int t[4] = '{40, 30, 16, 4};
    return t[p];
  endfunction

  // regulator model
  logic [3:0] vprev; int rc;
  always @(posedge clk) begin
    vprev <= vsel;
    if (!rst_n) begin vreg_ready <= 1'b1; rc <= 0; end
    else if (vsel != vprev && !stale) begin vreg_ready <= 1'b0; rc <= RD; end
    else if (rc != 0) begin rc <= rc - 1; if (rc == 1 && !reg_dead) vreg_ready <= 1'b1; end
    else if (!vreg_ready && !reg_dead) vreg_ready <= 1'b1;
  end

  // clock generator model
  logic [5:0] fprev; int lc;
  always @(posedge clk) begin
    fprev <= fsel;
    if (!rst_n) begin clk_locked <= 1'b1; lc <= 0; end
    else if (fsel != fprev && !stale) begin clk_locked <= 1'b0; lc <= LD; end
    else if (lc != 0) begin lc <= lc - 1; if (lc == 1 && !pll_dead) clk_locked <= 1'b1; end
    else if (!clk_locked && !pll_dead) clk_locked <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: scoreboard compare on done, ordering invariants every cycle
  int inv_bad = 0, gate_bad = 0;
  logic [5:0] f_seen;
  always @(negedge clk) begin
    if (rst_n) begin
      int need;
      need = (fsel > 30) ? 12 : (fsel > 16) ? 10 : (fsel > 4) ? 8 : 6;
      if (int'(vsel) < need) begin inv_bad++; $display("FAIL R3 actual=%0d expected=%0d", vsel, need); end
      if (fsel != f_seen && core_clk_en) begin gate_bad++; $display("FAIL R4 actual=%0d expected=%0d", core_clk_en, 0); end
      f_seen = fsel;
      if (done) begin
        if (q.size() == 0) chk(0, "R10 unexpected done", 1, 0);
        else begin
          item_t e;
          e = q.pop_front();
          chk(cur_point == e.pt, "R2/R3 point", cur_point, e.pt);
          chk(int'(vsel) == vt(e.pt), "R1 vsel", vsel, vt(e.pt));
          chk(int'(fsel) == ft(e.pt), "R1 fsel", fsel, ft(e.pt));
          chk(int'(trans_count) == e.cnt, "R8 count", trans_count, e.cnt);
          chk(err_timeout == e.to, "R9 timeout flag", err_timeout, e.to);
          chk(core_clk_en == 1'b1, "R4 clock back on", core_clk_en, 1);
        end
      end
    end else f_seen = fsel;
  end

  task automatic drain();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (q.size() == 0 && !busy) return;
    end
    chk(0, "R10 completion", 0, 1);
  endtask

  task automatic send(input logic [1:0] p, input bit fails);
    item_t e;
    if (fails) exp_to = 1'b1;
    else if (p != exp_pt) begin exp_pt = p; if (exp_cnt < 255) exp_cnt++; end
    e.pt = exp_pt; e.cnt = exp_cnt; e.to = exp_to;
    q.push_back(e);
    req_point = p; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(vsel == 4'd12 && fsel == 6'd40, "R1 reset codes", {vsel, fsel}, {4'd12, 6'd40});
    chk(core_clk_en && !busy && !done, "R1 reset controls", {core_clk_en, busy, done}, 3'b100);
    chk(!err_busy && !err_timeout && trans_count == 0 && cur_point == 0, "R1 reset flags", trans_count, 0);

    // R3 slow-down, R2 speed-up across several steps
    send(2'd2, 0); drain();
    send(2'd3, 0); drain();
    send(2'd0, 0); drain();
    send(2'd1, 0); drain();
    send(2'd3, 0); drain();
    send(2'd2, 0); drain();

    // R6 same point
    send(2'd2, 0);
    chk(done == 1'b1, "R6 done next cycle", done, 1);
    drain();

    // R5 with stale settle inputs: busy exactly 4 cycles
    stale = 1;
    begin
      int bc = 0;
      send(2'd1, 0);
      for (int i = 0; i < 20 && !done; i++) begin
        if (busy) bc++;
        @(negedge clk);
      end
      chk(bc == 4, "R5 busy length", bc, 4);
    end
    drain();
    send(2'd2, 0); drain();
    stale = 0;

    // R7 refusal while busy
    send(2'd0, 0);
    repeat (2) @(negedge clk);
    req_point = 2'd3; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(err_busy == 1'b1, "R7 sticky busy error", err_busy, 1);
    drain();
    chk(cur_point == 2'd0, "R7 refused request ignored", cur_point, 0);
    send(2'd2, 0); drain();
    chk(err_busy == 1'b1, "R7 flag stays", err_busy, 1);

    // R9 clock lock never arrives on a speed-up
    pll_dead = 1;
    send(2'd0, 1); drain();
    pll_dead = 0;
    repeat (3) @(negedge clk);
    // R9 regulator ready never arrives
    reg_dead = 1;
    send(2'd1, 1); drain();
    reg_dead = 0;
    repeat (3) @(negedge clk);
    send(2'd3, 0); drain();

    // R8 saturation
    stale = 1;
    for (int k = 0; k < 260; k++) begin
      send((exp_pt == 2'd3) ? 2'd2 : 2'd3, 0);
      drain();
    end
    chk(trans_count == 8'd255, "R8 saturated", trans_count, 255);
    stale = 0;

    chk(inv_bad == 0, "R2/R3 supply ordering", inv_bad, 0);
    chk(gate_bad == 0, "R4 gating", gate_bad, 0);
    chk(q.size() == 0, "R10 all completions seen", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule